// File: doc/BRIEF.md
# Three-Wire Attenuator Command Transmitter

This block sends one attenuation command to a serially programmed audio attenuator. The link has three lines: a data line, a clock line that the block generates itself, and a framing strobe line. A host offers an attenuation code on a valid/ready command port. The block builds a frame from the code, pulls the strobe line low, and shifts the frame out one bit per clock pulse, most significant bit first. It then raises the strobe line, which makes the attenuator commit the new setting.

All link timing is counted in system-clock cycles. One parameter sets the strobe-to-first-edge setup time, one sets the clock half-period, and one sets how long the strobe stays high before the block takes another command. The defaults give 150 ns or more at a 200 MHz system clock. The command port follows the usual valid/ready rules. A transfer happens on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from acceptance until the done pulse, so the host sees back-pressure for the whole frame. The host must hold `cmd_level` stable while `cmd_valid` is high and `cmd_ready` is low. A valid that arrives while the block is busy is not taken and changes nothing.

Top module: `atten_link_tx`

## Requirements
- R1: A frame is 16 bits sent on 16 rising edges of `link_clk`. The first 8 bits are the channel-select byte and the last 8 bits are the command code. Each bit is taken from `link_data` at a rising edge.
- R2: The channel-select byte is always 8'h00, whatever the command code is.
- R3: The code byte carries `cmd_level` unchanged, MSB first. This holds for all 256 values, including codes of 8'h3F and above.
- R4: `link_clk` idles high. It falls in the cycle after acceptance, and `link_load` falls exactly one cycle after that, so the clock falling edge comes first.
- R5: `link_load` stays low for exactly SETUP_CYC cycles before the first rising edge of `link_clk`.
- R6: `link_clk` is high for HALF_CYC cycles and low for HALF_CYC cycles, so rising edges are 2*HALF_CYC cycles apart. `link_data` changes only while `link_clk` is low or when it falls, and is stable across every high phase.
- R7: `link_load` rises HALF_CYC cycles after the 16th rising edge. At that point `link_clk` is high and `link_data` is low.
- R8: `done` is a one-cycle pulse HOLD_CYC cycles after `link_load` rises. `busy` is high from the cycle after acceptance until that pulse, and `cmd_ready` equals not `busy`.
- R9: A `cmd_valid` while busy is ignored. It neither changes the frame in flight nor starts another frame.
- R10: A synchronous active-high `rst` leaves `link_load` high, `link_clk` high, `link_data` low, and `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_level | input | CODE_W | Attenuation code |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at end of frame |
| link_data | output | 1 | Serial data line |
| link_clk | output | 1 | Serial clock line, idles high |
| link_load | output | 1 | Framing strobe, low during a frame |

## Verification
Every result is counted from the acceptance edge, called cycle 0:
- `link_clk` falls after cycle 0.
- `link_load` falls after cycle 1.
- The first rising edge is due at 1+SETUP_CYC, and later rising edges follow every 2*HALF_CYC cycles.
- `link_load` rises at 1+SETUP_CYC+31*HALF_CYC.
- `done` comes HOLD_CYC cycles after that.

The bench samples on the falling system-clock edge after each active edge and numbers these samples from the acceptance edge. It records the sample index of each observed transition and compares it with these formulas. A separate idle window after each frame shows that an ignored command left no trace.

// File: rtl/atten_link_pkg.sv
package atten_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SETUP = 3'd2,
    ST_HIGH  = 3'd3,
    ST_LOW   = 3'd4,
    ST_HOLD  = 3'd5
  } lk_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - CW'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign last = (cnt == '0);

  a_r6_load_nonzero: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));
endmodule

// File: rtl/atten_frame_shifter.sv
module atten_frame_shifter #(
  parameter int ADDR_W = 8,
  parameter int CODE_W = 8,
  parameter logic [ADDR_W-1:0] CHAN_SEL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              shift,
  output logic              sdo,
  output logic              bit_last
);
  localparam int FRAME_BITS = ADDR_W + CODE_W;
  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sr;
  logic [IW-1:0]         idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= {CHAN_SEL, code};
      idx <= '0;
    end else if (shift) begin
      sr  <= {sr[FRAME_BITS-2:0], 1'b0};
      idx <= idx + IW'(1);
    end
  end

  assign sdo      = sr[FRAME_BITS-1];
  assign bit_last = (idx == IW'(FRAME_BITS-1));

  a_r9_frame_held: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> $stable(sr));
endmodule

// File: rtl/atten_link_seq.sv
module atten_link_seq
  import atten_link_pkg::*;
#(
  parameter int SETUP_CYC = 30,
  parameter int HALF_CYC  = 30,
  parameter int HOLD_CYC  = 30,
  parameter int CW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          tmr_last,
  input  logic          bit_last,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          sh_load,
  output logic          sh_shift,
  output logic          link_clk_q,
  output logic          link_load_q,
  output logic          done_q,
  output logic          idle
);
  lk_state_e state, nxt;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        nxt     = ST_LEAD;
        sh_load = 1'b1;
      end
      ST_LEAD: begin
        nxt      = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = CW'(SETUP_CYC);
      end
      ST_SETUP: if (tmr_last) begin
        nxt      = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = CW'(HALF_CYC);
      end
      ST_HIGH: if (tmr_last) begin
        sh_shift = 1'b1;
        tmr_load = 1'b1;
        if (bit_last) begin
          nxt     = ST_HOLD;
          tmr_val = CW'(HOLD_CYC);
        end else begin
          nxt     = ST_LOW;
          tmr_val = CW'(HALF_CYC);
        end
      end
      ST_LOW: if (tmr_last) begin
        nxt      = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = CW'(HALF_CYC);
      end
      ST_HOLD: if (tmr_last) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      link_clk_q  <= 1'b1;
      link_load_q <= 1'b1;
      done_q      <= 1'b0;
    end else begin
      state       <= nxt;
      link_clk_q  <= !(nxt == ST_LEAD || nxt == ST_SETUP || nxt == ST_LOW);
      link_load_q <= !(nxt == ST_SETUP || nxt == ST_HIGH || nxt == ST_LOW);
      done_q      <= (state == ST_HOLD) && tmr_last;
    end
  end

  assign idle = (state == ST_IDLE);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r4_clk_leads_load: assert property (@(posedge clk) disable iff (rst)
    $fell(link_load_q) |-> (!link_clk_q && !$past(link_clk_q)));
  a_r7_load_rise_clk_high: assert property (@(posedge clk) disable iff (rst)
    $rose(link_load_q) |-> link_clk_q);
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> idle);
endmodule

// File: rtl/atten_link_tx.sv
module atten_link_tx
  import atten_link_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CODE_W    = 8,
  parameter int SETUP_CYC = 30,
  parameter int HALF_CYC  = 30,
  parameter int HOLD_CYC  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CODE_W-1:0] cmd_level,
  output logic              busy,
  output logic              done,
  output logic              link_data,
  output logic              link_clk,
  output logic              link_load
);
  localparam int MAXC = max3(SETUP_CYC, HALF_CYC, HOLD_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  logic          start, tmr_load, tmr_last, sh_load, sh_shift, bit_last, idle;
  logic [CW-1:0] tmr_val;

  assign start     = cmd_valid && cmd_ready;
  assign cmd_ready = idle;
  assign busy      = !idle;

  atten_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  atten_frame_shifter #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .CHAN_SEL('0)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .code(cmd_level), .shift(sh_shift),
    .sdo(link_data), .bit_last(bit_last)
  );

  atten_link_seq #(
    .SETUP_CYC(SETUP_CYC), .HALF_CYC(HALF_CYC), .HOLD_CYC(HOLD_CYC), .CW(CW)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .tmr_last(tmr_last), .bit_last(bit_last),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .sh_load(sh_load), .sh_shift(sh_shift),
    .link_clk_q(link_clk), .link_load_q(link_load), .done_q(done), .idle(idle)
  );

  a_r6_data_steady_high: assert property (@(posedge clk) disable iff (rst)
    (!link_load && link_clk && $past(link_clk)) |-> $stable(link_data));
  a_r9_start_only_when_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid && cmd_ready));
  a_r10_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (link_load && link_clk && !link_data && !busy && !done));
endmodule

// File: tb/test_atten_link_tx.sv
module test_atten_link_tx;
  localparam int S = 30, H = 30, HD = 30;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0;
  logic [7:0] cmd_level = 8'h00;
  logic cmd_ready, busy, done, link_data, link_clk, link_load;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  atten_link_tx #(.ADDR_W(8), .CODE_W(8), .SETUP_CYC(S), .HALF_CYC(H), .HOLD_CYC(HD))
  i_atten_link_tx (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_level(cmd_level), .busy(busy), .done(done), .link_data(link_data),
    .link_clk(link_clk), .link_load(link_load)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R10: idle levels while held in reset
    chk(link_load == 1'b1, "R10 load", int'(link_load), 1);
    chk(link_clk == 1'b1, "R10 clk", int'(link_clk), 1);
    chk(link_data == 1'b0, "R10 data", int'(link_data), 0);
    chk(busy == 1'b0 && done == 1'b0, "R10 busy/done", int'({busy, done}), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_frame(input logic [7:0] code, input bit inject);
    int n, rises, first_rise, prev_rise, bad_space, load_fall, clk_fall;
    int load_rise, done_at, done_cnt, busy_bad;
    logic [15:0] got;
    logic pclk, pload, clk_at_lr, data_at_lr;
    rises = 0; first_rise = -1; prev_rise = -1; bad_space = 0; load_fall = -1;
    clk_fall = -1; load_rise = -1; done_at = -1; done_cnt = 0; busy_bad = 0;
    got = '0; pclk = 1'b1; pload = 1'b1; clk_at_lr = 1'b0; data_at_lr = 1'b1;
    // R8: ready before the command is offered
    chk(cmd_ready == 1'b1, "R8 ready idle", int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_level = code;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (n < 4000 && (done_at < 0 || n < done_at + 5)) begin
      if (pclk && !link_clk && clk_fall < 0) clk_fall = n;
      if (pload && !link_load) load_fall = n;
      if (!pload && link_load) begin
        load_rise = n; clk_at_lr = link_clk; data_at_lr = link_data;
      end
      if (!pclk && link_clk) begin
        got = {got[14:0], link_data};
        if (first_rise < 0) first_rise = n;
        if (prev_rise >= 0 && n - prev_rise != 2 * H) bad_space++;
        prev_rise = n; rises++;
      end
      if (done) begin done_cnt++; if (done_at < 0) done_at = n; end
      if (done_at < 0 && !busy) busy_bad++;
      if (done_at < 0 && busy == cmd_ready) busy_bad++;
      pclk = link_clk; pload = link_load;
      if (inject && n == 200) begin cmd_valid = 1'b1; cmd_level = ~code; end
      if (inject && n == 201) cmd_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(rises == 16, "R1 edge count", rises, 16);
    chk(got == {8'h00, code}, "R1 frame", int'(got), int'({8'h00, code}));
    chk(got[15:8] == 8'h00, "R2 select byte", int'(got[15:8]), 0);
    chk(got[7:0] == code, "R3 code byte", int'(got[7:0]), int'(code));
    chk(clk_fall == 0, "R4 clk fall", clk_fall, 0);
    chk(load_fall == 1, "R4 load fall", load_fall, 1);
    chk(first_rise == 1 + S, "R5 setup", first_rise, 1 + S);
    chk(bad_space == 0, "R6 spacing", bad_space, 0);
    chk(load_rise == 1 + S + 31 * H, "R7 load rise", load_rise, 1 + S + 31 * H);
    chk(clk_at_lr == 1'b1 && data_at_lr == 1'b0, "R7 levels", int'({clk_at_lr, data_at_lr}), 2);
    chk(done_at == 1 + S + 31 * H + HD, "R8 done time", done_at, 1 + S + 31 * H + HD);
    chk(done_cnt == 1, "R8 done single", done_cnt, 1);
    chk(busy_bad == 0, "R8 busy/ready", busy_bad, 0);
  endtask

  task automatic t_quiet();
    int moved;
    moved = 0;
    // R9: no follow-on frame after an ignored command
    for (int i = 0; i < 60; i++) begin
      if (!link_load || !link_clk || busy || done) moved++;
      @(negedge clk);
    end
    chk(moved == 0, "R9 no stray frame", moved, 0);
  endtask

  initial begin
    t_reset();
    t_frame(8'h00, 1'b0);
    t_frame(8'h3F, 1'b0);
    t_frame(8'hFF, 1'b0);
    t_frame(8'hA5, 1'b1);
    t_quiet();
    t_frame(8'h3E, 1'b0);
    t_reset();
    t_frame(8'h01, 1'b0);
    finish_run();
  end
endmodule